// File: doc/BRIEF.md
# Thread-Block Work Distributor

This block takes one launch at a time, each describing a grid of independent thread blocks. A grid is up to three dimensions of blocks. Every block has the same shape, which is also up to three dimensions of threads. The distributor walks the grid one block at a time and offers each block to one of several multiprocessor slots. A slot is chosen only if its free capacity can hold the block. Capacity is counted in whole warps of threads. Each offer carries the block's linear id, its grid coordinates, its thread count and its warp count.

When a slot finishes a block, it raises a completion pulse that returns the block's warps, and the distributor credits them back at once. A launch is accepted only while the distributor is idle. It becomes idle again only after every block of the running grid has retired. Successive grids therefore never overlap, while blocks of one grid spread over all slots.

A host presents a launch with a valid strobe while `launch_ready` is high. A malformed launch is turned away with a one-cycle reject pulse. Completion of a grid is signalled by a one-cycle `grid_done` pulse.

Top module: `grid_block_distributor`

## Requirements
- R1: A launch is rejected when any of the following holds: the product of the three block dimensions is 0, that product exceeds 512, or any grid dimension is 0. A rejected launch raises `launch_reject` for the one cycle after the launch handshake, and it dispatches nothing. `launch_ready` stays high after a rejection.
- R2: The thread count of a block is the product of its three dimensions. `disp_threads` carries that count. `disp_warps` carries the count divided by 32, rounded up.
- R3: Each slot starts with 24 free warps (768 threads). A block is offered only to a slot whose free warps are at least the block's warp count. Accepting a block subtracts its warps from that slot.
- R4: A completion pulse on `retire_pulse[s]` returns the warps on field s of `retire_warps` to slot s on the same clock edge. A block stalled for lack of room can be offered to that slot in the second cycle after the pulse.
- R5: When no slot has room, no offer is made and the pending block is kept. The same block is offered later, once capacity has been returned.
- R6: Blocks are offered in ascending linear id from 0 to (gx*gy*gz - 1). The id is x + y*gx + z*gx*gy. `disp_x` varies fastest, then `disp_y`, then `disp_z`.
- R7: The slot is chosen round-robin. The search starts at the slot after the one that took the previous block and wraps around. It takes the first slot with enough room.
- R8: `launch_ready` is low from an accepted launch until the grid completes. No offer is made while it is high.
- R9: `grid_done` is high for exactly the one cycle after the edge that takes the completion pulse of the last outstanding block. `launch_ready` returns high in that same cycle.
- R10: At most one bit of `disp_valid` is high at a time, the high bit selecting the target slot. An offer and its fields stay unchanged until that slot's `disp_ready` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch descriptor present |
| launch_ready | output | 1 | Distributor idle, able to take a launch |
| grid_x | input | GRID_DIM_W | Grid size in blocks, x |
| grid_y | input | GRID_DIM_W | Grid size in blocks, y |
| grid_z | input | GRID_DIM_W | Grid size in blocks, z |
| blk_x | input | BLK_DIM_W | Block size in threads, x |
| blk_y | input | BLK_DIM_W | Block size in threads, y |
| blk_z | input | BLK_DIM_W | Block size in threads, z |
| launch_reject | output | 1 | One-cycle pulse after a malformed launch |
| disp_valid | output | NUM_SLOTS | One-hot offer to a slot |
| disp_ready | input | NUM_SLOTS | Per-slot acceptance |
| disp_block_id | output | 3*GRID_DIM_W | Linear id of the offered block |
| disp_x | output | GRID_DIM_W | Grid coordinate x of the offered block |
| disp_y | output | GRID_DIM_W | Grid coordinate y of the offered block |
| disp_z | output | GRID_DIM_W | Grid coordinate z of the offered block |
| disp_threads | output | clog2(MAX_BLK_THREADS+1) | Threads in the offered block |
| disp_warps | output | WCNT_W | Warps the offered block occupies |
| retire_pulse | input | NUM_SLOTS | Per-slot completion pulse |
| retire_warps | input | NUM_SLOTS*WCNT_W | Warps returned by each slot, field s for slot s |
| grid_done | output | 1 | One-cycle pulse when the grid has fully retired |

## Verification
The assertions take for granted that each slot pulses completion only for a block it actually holds. They also assume it returns exactly that block's warp count, so a slot's free warps never climb above 24. The stimulus keeps to this by modelling every slot's resident blocks and retiring only blocks it was given, with the grid's warp count. A launch is presented only while `launch_ready` is high. Each slot pulses completion at most once per cycle.

// File: rtl/gbd_pkg.sv
// Shared types and helpers for the thread-block work distributor.
package gbd_pkg;

    // Run state of the launch controller.
    typedef enum logic {
        GBD_IDLE = 1'b0,
        GBD_RUN  = 1'b1
    } gbd_state_e;

    // Number of whole warps needed to hold a given thread count.
    function automatic int unsigned warps_for(input int unsigned threads,
                                              input int unsigned wsz);
        return (threads + wsz - 1) / wsz;
    endfunction

endpackage

// File: rtl/gbd_launch_ctrl.sv
// Launch controller.
// Validates a launch, latches the grid and block shape, and walks the block
// coordinates in linear order as blocks are accepted. It counts blocks that are
// resident in slots and signals grid completion.
// Assumes: a launch is presented only while launch_ready is high; retire_cnt
// never exceeds the number of resident blocks.
module gbd_launch_ctrl
    import gbd_pkg::*;
#(
    parameter int GRID_DIM_W      = 8,
    parameter int BLK_DIM_W       = 10,
    parameter int MAX_BLK_THREADS = 512,
    parameter int WARP_SIZE       = 32,
    parameter int WCNT_W          = 5,
    parameter int CNT_W           = 3,
    parameter int OUT_W           = 7,
    localparam int BID_W          = 3 * GRID_DIM_W,
    localparam int PROD_W         = 3 * BLK_DIM_W,
    localparam int THR_W          = $clog2(MAX_BLK_THREADS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_valid,
    input  logic [GRID_DIM_W-1:0] grid_x,
    input  logic [GRID_DIM_W-1:0] grid_y,
    input  logic [GRID_DIM_W-1:0] grid_z,
    input  logic [BLK_DIM_W-1:0]  blk_x,
    input  logic [BLK_DIM_W-1:0]  blk_y,
    input  logic [BLK_DIM_W-1:0]  blk_z,
    input  logic                  accept,
    input  logic [CNT_W-1:0]      retire_cnt,
    output logic                  launch_ready,
    output logic                  launch_reject,
    output logic                  pending,
    output logic [BID_W-1:0]      cur_id,
    output logic [GRID_DIM_W-1:0] cur_x,
    output logic [GRID_DIM_W-1:0] cur_y,
    output logic [GRID_DIM_W-1:0] cur_z,
    output logic [THR_W-1:0]      blk_threads,
    output logic [WCNT_W-1:0]     blk_warps,
    output logic                  grid_done
);

    gbd_state_e            state_q;
    logic [GRID_DIM_W-1:0] lim_x, lim_y, lim_z;
    logic [BID_W-1:0]      total_q;
    logic [OUT_W-1:0]      resident_q;
    logic [OUT_W-1:0]      resident_nxt;
    logic [BID_W-1:0]      issued_nxt;
    logic [PROD_W-1:0]     req_threads;
    logic [BID_W-1:0]      req_total;
    logic                  req_ok;

    // Shape arithmetic of the presented launch.
    always_comb begin
        req_threads = PROD_W'(blk_x) * PROD_W'(blk_y) * PROD_W'(blk_z);
        req_total   = BID_W'(grid_x) * BID_W'(grid_y) * BID_W'(grid_z);
        req_ok      = (req_threads != '0)
                   && (req_threads <= PROD_W'(MAX_BLK_THREADS))
                   && (grid_x != '0) && (grid_y != '0) && (grid_z != '0);
    end

    // Resident-block count and issue count after this cycle.
    always_comb begin
        resident_nxt = resident_q + OUT_W'(accept) - OUT_W'(retire_cnt);
        issued_nxt   = accept ? (cur_id + BID_W'(1)) : cur_id;
    end

    assign launch_ready = (state_q == GBD_IDLE);
    assign pending      = (state_q == GBD_RUN) && (cur_id != total_q);

    // Launch acceptance, coordinate walk and grid completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= GBD_IDLE;
            lim_x         <= '0;
            lim_y         <= '0;
            lim_z         <= '0;
            total_q       <= '0;
            cur_id        <= '0;
            cur_x         <= '0;
            cur_y         <= '0;
            cur_z         <= '0;
            blk_threads   <= '0;
            blk_warps     <= '0;
            resident_q    <= '0;
            launch_reject <= 1'b0;
            grid_done     <= 1'b0;
        end else begin
            launch_reject <= 1'b0;
            grid_done     <= 1'b0;
            resident_q    <= resident_nxt;
            case (state_q)
                GBD_IDLE: begin
                    if (launch_valid) begin
                        if (req_ok) begin
                            state_q     <= GBD_RUN;
                            lim_x       <= grid_x;
                            lim_y       <= grid_y;
                            lim_z       <= grid_z;
                            total_q     <= req_total;
                            cur_id      <= '0;
                            cur_x       <= '0;
                            cur_y       <= '0;
                            cur_z       <= '0;
                            blk_threads <= THR_W'(req_threads);
                            blk_warps   <= WCNT_W'(warps_for(32'(req_threads), WARP_SIZE));
                        end else begin
                            launch_reject <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (accept) begin
                        cur_id <= issued_nxt;
                        if (cur_x == lim_x - GRID_DIM_W'(1)) begin
                            cur_x <= '0;
                            if (cur_y == lim_y - GRID_DIM_W'(1)) begin
                                cur_y <= '0;
                                cur_z <= cur_z + GRID_DIM_W'(1);
                            end else begin
                                cur_y <= cur_y + GRID_DIM_W'(1);
                            end
                        end else begin
                            cur_x <= cur_x + GRID_DIM_W'(1);
                        end
                    end
                    if ((issued_nxt == total_q) && (resident_nxt == '0)) begin
                        grid_done <= 1'b1;
                        state_q   <= GBD_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/gbd_slot_ledger.sv
// Slot capacity ledger.
// Keeps the free warp count of every slot. It subtracts a block's warps when
// the block is accepted and adds back returned warps on a completion pulse, in
// the same edge. It flags the slots that can hold the pending block.
// Assumes: completion pulses return only warps actually held by the slot.
module gbd_slot_ledger #(
    parameter int NUM_SLOTS  = 4,
    parameter int SLOT_WARPS = 24,
    parameter int WCNT_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        take,
    input  logic [WCNT_W-1:0]           take_warps,
    input  logic [NUM_SLOTS-1:0]        ret_pulse,
    input  logic [NUM_SLOTS*WCNT_W-1:0] ret_warps,
    input  logic [WCNT_W-1:0]           need,
    output logic [NUM_SLOTS*WCNT_W-1:0] free_flat,
    output logic [NUM_SLOTS-1:0]        fit
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [WCNT_W-1:0] free_q;
        logic [WCNT_W-1:0] ret_w;
        logic [WCNT_W-1:0] take_w;

        assign ret_w  = ret_pulse[s] ? ret_warps[s*WCNT_W +: WCNT_W] : '0;
        assign take_w = take[s] ? take_warps : '0;

        // Per-slot free warp register with simultaneous take and return.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                free_q <= WCNT_W'(SLOT_WARPS);
            end else begin
                free_q <= free_q - take_w + ret_w;
            end
        end

        assign free_flat[s*WCNT_W +: WCNT_W] = free_q;
        assign fit[s] = (free_q >= need);
    end

endmodule

// File: rtl/gbd_slot_pick.sv
// Round-robin slot picker and offer register.
// When a block is pending and no offer is open, it picks the first slot with
// room, searching from the round-robin pointer. It then holds a one-hot offer
// to that slot until the slot accepts.
// Assumes: the slot's room can only grow while the offer is open, because only
// this offer consumes capacity.
module gbd_slot_pick #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pending,
    input  logic [NUM_SLOTS-1:0] fit,
    input  logic [NUM_SLOTS-1:0] slot_ready,
    output logic [NUM_SLOTS-1:0] offer_vec,
    output logic                 accept
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] offer_slot;
    logic             offer_q;
    logic             pick_found;
    logic [IDX_W-1:0] pick_slot;
    logic [IDX_W-1:0] rr_after;
    int               cand;
    int               nx;

    // First fitting slot at or after the pointer, with wrap-around.
    always_comb begin
        pick_found = 1'b0;
        pick_slot  = '0;
        cand       = 0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            cand = int'(rr_q) + k;
            if (cand >= NUM_SLOTS) cand = cand - NUM_SLOTS;
            if (!pick_found && fit[IDX_W'(cand)]) begin
                pick_found = 1'b1;
                pick_slot  = IDX_W'(cand);
            end
        end
    end

    // Pointer value after taking the picked slot.
    always_comb begin
        nx       = int'(pick_slot) + 1;
        rr_after = (nx >= NUM_SLOTS) ? '0 : IDX_W'(nx);
    end

    assign accept = offer_q && slot_ready[offer_slot];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_vec
        assign offer_vec[s] = offer_q && (offer_slot == IDX_W'(s));
    end

    // Open, hold and close the single outstanding offer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q       <= '0;
            offer_slot <= '0;
            offer_q    <= 1'b0;
        end else if (!offer_q) begin
            if (pending && pick_found) begin
                offer_q    <= 1'b1;
                offer_slot <= pick_slot;
                rr_q       <= rr_after;
            end
        end else if (accept) begin
            offer_q <= 1'b0;
        end
    end

endmodule

// File: rtl/grid_block_distributor.sv
// Thread-block work distributor top.
// Accepts one grid launch at a time and offers its blocks, in linear order, to
// slots with enough free warp capacity. Capacity is credited back on
// completion pulses, and a one-cycle done pulse follows the grid's last
// retirement.
// Assumes: each slot pulses completion only for blocks it holds, with the
// block's own warp count.
module grid_block_distributor
    import gbd_pkg::*;
#(
    parameter int NUM_SLOTS       = 4,
    parameter int GRID_DIM_W      = 8,
    parameter int BLK_DIM_W       = 10,
    parameter int MAX_BLK_THREADS = 512,
    parameter int SLOT_THREADS    = 768,
    parameter int WARP_SIZE       = 32,
    localparam int SLOT_WARPS     = SLOT_THREADS / WARP_SIZE,
    localparam int WCNT_W         = $clog2(SLOT_WARPS + 1),
    localparam int THR_W          = $clog2(MAX_BLK_THREADS + 1),
    localparam int BID_W          = 3 * GRID_DIM_W,
    localparam int CNT_W          = $clog2(NUM_SLOTS + 1),
    localparam int OUT_W          = $clog2(NUM_SLOTS * SLOT_WARPS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        launch_valid,
    output logic                        launch_ready,
    input  logic [GRID_DIM_W-1:0]       grid_x,
    input  logic [GRID_DIM_W-1:0]       grid_y,
    input  logic [GRID_DIM_W-1:0]       grid_z,
    input  logic [BLK_DIM_W-1:0]        blk_x,
    input  logic [BLK_DIM_W-1:0]        blk_y,
    input  logic [BLK_DIM_W-1:0]        blk_z,
    output logic                        launch_reject,
    output logic [NUM_SLOTS-1:0]        disp_valid,
    input  logic [NUM_SLOTS-1:0]        disp_ready,
    output logic [BID_W-1:0]            disp_block_id,
    output logic [GRID_DIM_W-1:0]       disp_x,
    output logic [GRID_DIM_W-1:0]       disp_y,
    output logic [GRID_DIM_W-1:0]       disp_z,
    output logic [THR_W-1:0]            disp_threads,
    output logic [WCNT_W-1:0]           disp_warps,
    input  logic [NUM_SLOTS-1:0]        retire_pulse,
    input  logic [NUM_SLOTS*WCNT_W-1:0] retire_warps,
    output logic                        grid_done
);

    logic                        pending;
    logic                        offer_accept;
    logic [NUM_SLOTS-1:0]        slot_fit;
    logic [NUM_SLOTS-1:0]        slot_take;
    logic [NUM_SLOTS*WCNT_W-1:0] slot_free_flat;
    logic [CNT_W-1:0]            retire_cnt;

    // Number of slots retiring a block this cycle.
    always_comb begin
        retire_cnt = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            retire_cnt = retire_cnt + CNT_W'(retire_pulse[s]);
        end
    end

    assign slot_take = offer_accept ? disp_valid : '0;

    gbd_launch_ctrl #(
        .GRID_DIM_W      (GRID_DIM_W),
        .BLK_DIM_W       (BLK_DIM_W),
        .MAX_BLK_THREADS (MAX_BLK_THREADS),
        .WARP_SIZE       (WARP_SIZE),
        .WCNT_W          (WCNT_W),
        .CNT_W           (CNT_W),
        .OUT_W           (OUT_W)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch_valid  (launch_valid),
        .grid_x        (grid_x),
        .grid_y        (grid_y),
        .grid_z        (grid_z),
        .blk_x         (blk_x),
        .blk_y         (blk_y),
        .blk_z         (blk_z),
        .accept        (offer_accept),
        .retire_cnt    (retire_cnt),
        .launch_ready  (launch_ready),
        .launch_reject (launch_reject),
        .pending       (pending),
        .cur_id        (disp_block_id),
        .cur_x         (disp_x),
        .cur_y         (disp_y),
        .cur_z         (disp_z),
        .blk_threads   (disp_threads),
        .blk_warps     (disp_warps),
        .grid_done     (grid_done)
    );

    gbd_slot_ledger #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_WARPS (SLOT_WARPS),
        .WCNT_W     (WCNT_W)
    ) ledger_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (slot_take),
        .take_warps (disp_warps),
        .ret_pulse  (retire_pulse),
        .ret_warps  (retire_warps),
        .need       (disp_warps),
        .free_flat  (slot_free_flat),
        .fit        (slot_fit)
    );

    gbd_slot_pick #(
        .NUM_SLOTS (NUM_SLOTS)
    ) pick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .fit        (slot_fit),
        .slot_ready (disp_ready),
        .offer_vec  (disp_valid),
        .accept     (offer_accept)
    );

endmodule

// File: rtl/gbd_checker.sv
// Protocol and capacity checker for the work distributor, attached by bind.
// Assumes: slots return only the warps they hold.
module gbd_checker #(
    parameter int NUM_SLOTS  = 4,
    parameter int GRID_DIM_W = 8,
    parameter int THR_W      = 10,
    parameter int WARP_SIZE  = 32,
    parameter int SLOT_WARPS = 24,
    parameter int WCNT_W     = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        launch_valid,
    input logic                        launch_ready,
    input logic                        launch_reject,
    input logic [NUM_SLOTS-1:0]        disp_valid,
    input logic [3*GRID_DIM_W-1:0]     disp_block_id,
    input logic [THR_W-1:0]            disp_threads,
    input logic [WCNT_W-1:0]           disp_warps,
    input logic [NUM_SLOTS-1:0]        retire_pulse,
    input logic                        grid_done,
    input logic [NUM_SLOTS*WCNT_W-1:0] slot_free_flat,
    input logic                        offer_accept
);

    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|disp_valid) && !offer_accept) |=>
            ((disp_valid == $past(disp_valid)) && (disp_block_id == $past(disp_block_id))));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ready |-> (disp_valid == '0));

    assert_done_after_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grid_done |-> $past(|retire_pulse));

    assert_reject_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch_reject |-> $past(launch_valid && launch_ready));

    assert_warp_round_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|disp_valid) |-> ((int'(disp_warps) * WARP_SIZE >= int'(disp_threads))
                        && ((int'(disp_warps) - 1) * WARP_SIZE < int'(disp_threads))));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
        assert_fit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid[s] |-> (slot_free_flat[s*WCNT_W +: WCNT_W] >= disp_warps));

        assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            slot_free_flat[s*WCNT_W +: WCNT_W] <= WCNT_W'(SLOT_WARPS));
    end

endmodule

bind grid_block_distributor gbd_checker #(
    .NUM_SLOTS  (NUM_SLOTS),
    .GRID_DIM_W (GRID_DIM_W),
    .THR_W      (THR_W),
    .WARP_SIZE  (WARP_SIZE),
    .SLOT_WARPS (SLOT_WARPS),
    .WCNT_W     (WCNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_valid   (launch_valid),
    .launch_ready   (launch_ready),
    .launch_reject  (launch_reject),
    .disp_valid     (disp_valid),
    .disp_block_id  (disp_block_id),
    .disp_threads   (disp_threads),
    .disp_warps     (disp_warps),
    .retire_pulse   (retire_pulse),
    .grid_done      (grid_done),
    .slot_free_flat (slot_free_flat),
    .offer_accept   (offer_accept)
);

// File: tb/grid_block_distributor_tb.sv
// Directed bench for the work distributor, with a model of slot occupancy.
module grid_block_distributor_tb_top;

    localparam int N  = 4;
    localparam int WW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          launch_valid = 1'b0;
    logic          launch_ready;
    logic [7:0]    grid_x = '0, grid_y = '0, grid_z = '0;
    logic [9:0]    blk_x = '0, blk_y = '0, blk_z = '0;
    logic          launch_reject;
    logic [N-1:0]  disp_valid;
    logic [N-1:0]  disp_ready = '1;
    logic [23:0]   disp_block_id;
    logic [7:0]    disp_x, disp_y, disp_z;
    logic [9:0]    disp_threads;
    logic [WW-1:0] disp_warps;
    logic [N-1:0]  retire_pulse = '0;
    logic [N*WW-1:0] retire_warps = '0;
    logic          grid_done;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model
    int m_free [N];
    int m_blocks [N];
    int m_rr = 0;
    int m_warps = 0, m_threads = 0;
    int m_gx = 1, m_gy = 1;
    int m_next_id = 0;
    int last_slot = -1;
    int last_wait = 0;

    grid_block_distributor dut_i (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_ready(launch_ready),
        .grid_x(grid_x), .grid_y(grid_y), .grid_z(grid_z),
        .blk_x(blk_x), .blk_y(blk_y), .blk_z(blk_z),
        .launch_reject(launch_reject),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_block_id(disp_block_id),
        .disp_x(disp_x), .disp_y(disp_y), .disp_z(disp_z),
        .disp_threads(disp_threads), .disp_warps(disp_warps),
        .retire_pulse(retire_pulse), .retire_warps(retire_warps),
        .grid_done(grid_done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    task automatic do_launch(input int gx, gy, gz, bx, by, bz);
        @(negedge clk);
        grid_x = 8'(gx); grid_y = 8'(gy); grid_z = 8'(gz);
        blk_x = 10'(bx); blk_y = 10'(by); blk_z = 10'(bz);
        launch_valid = 1'b1;
        @(negedge clk);
        launch_valid = 1'b0;
        m_gx = gx; m_gy = gy;
        m_threads = bx * by * bz;
        m_warps = (m_threads + 31) / 32;
        m_next_id = 0;
    endtask

    // Wait for an offer and compare it with the model; the offer is assumed accepted.
    task automatic expect_offer(input string req);
        int got;
        int pred;
        int id;
        got = -1;
        pred = -1;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (m_rr + k) % N;
            if (pred < 0 && m_free[c] >= m_warps) pred = c;
        end
        last_wait = 0;
        for (int i = 0; i < 30 && got < 0; i++) begin
            @(negedge clk); #1;
            last_wait++;
            for (int s = 0; s < N; s++) if (disp_valid[s]) got = s;
        end
        id = m_next_id;
        check(got == pred, {req, " R7 slot choice"}, got, pred);
        check(disp_block_id == 24'(id), {req, " R6 block id"}, int'(disp_block_id), id);
        check(disp_x == 8'(id % m_gx), {req, " R6 coord x"}, int'(disp_x), id % m_gx);
        check(disp_y == 8'((id / m_gx) % m_gy), {req, " R6 coord y"}, int'(disp_y), (id / m_gx) % m_gy);
        check(disp_z == 8'(id / (m_gx * m_gy)), {req, " R6 coord z"}, int'(disp_z), id / (m_gx * m_gy));
        check(disp_threads == 10'(m_threads), {req, " R2 threads"}, int'(disp_threads), m_threads);
        check(disp_warps == WW'(m_warps), {req, " R2 warps"}, int'(disp_warps), m_warps);
        if (got >= 0) begin
            m_free[got] -= m_warps;
            m_blocks[got]++;
            m_rr = (got + 1) % N;
        end
        last_slot = got;
        m_next_id++;
    endtask

    task automatic retire(input int s);
        @(negedge clk);
        retire_pulse[s] = 1'b1;
        retire_warps[s*WW +: WW] = WW'(m_warps);
        @(negedge clk);
        retire_pulse = '0;
        retire_warps = '0;
        m_free[s] += m_warps;
        m_blocks[s]--;
    endtask

    // Retire every resident block and check the grid-done timing.
    task automatic retire_all(input string req);
        int left;
        left = 0;
        for (int s = 0; s < N; s++) left += m_blocks[s];
        for (int s = 0; s < N; s++) begin
            while (m_blocks[s] > 0) begin
                if (left == 1) begin
                    #1;
                    check(grid_done == 1'b0, {req, " R9 no early done"}, int'(grid_done), 0);
                    check(launch_ready == 1'b0, {req, " R8 busy until retired"}, int'(launch_ready), 0);
                end
                retire(s);
                left--;
            end
        end
        #1;
        check(grid_done == 1'b1, {req, " R9 done after last retire"}, int'(grid_done), 1);
        check(launch_ready == 1'b1, {req, " R9 ready with done"}, int'(launch_ready), 1);
        @(negedge clk); #1;
        check(grid_done == 1'b0, {req, " R9 single cycle"}, int'(grid_done), 0);
    endtask

    task automatic t_reset();
        check(launch_ready == 1'b1, "reset R8 ready", int'(launch_ready), 1);
        check(disp_valid == '0, "reset R10 no offer", int'(disp_valid), 0);
        check(grid_done == 1'b0, "reset R9 done low", int'(grid_done), 0);
        check(launch_reject == 1'b0, "reset R1 reject low", int'(launch_reject), 0);
    endtask

    task automatic bad_launch(input int gx, gy, gz, bx, by, bz, input string what);
        do_launch(gx, gy, gz, bx, by, bz);
        #1;
        check(launch_reject == 1'b1, {"R1 reject pulse ", what}, int'(launch_reject), 1);
        check(launch_ready == 1'b1, {"R1 stays ready ", what}, int'(launch_ready), 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(disp_valid == '0, {"R1 nothing dispatched ", what}, int'(disp_valid), 0);
            check(launch_reject == 1'b0, {"R1 pulse ended ", what}, int'(launch_reject), 0);
        end
    endtask

    task automatic t_reject();
        bad_launch(2, 2, 1, 0, 4, 4, "zero threads");
        bad_launch(2, 2, 1, 27, 19, 1, "513 threads");
        bad_launch(2, 0, 1, 8, 4, 1, "zero grid dim");
    endtask

    task automatic t_walk();
        do_launch(3, 2, 2, 3, 5, 3);   // 45 threads, 2 warps
        #1;
        check(launch_ready == 1'b0, "walk R8 busy after launch", int'(launch_ready), 0);
        for (int b = 0; b < 12; b++) expect_offer("walk");
        retire_all("walk");
    endtask

    task automatic t_stall();
        do_launch(6, 1, 1, 16, 16, 2); // 512 threads, 16 warps
        for (int b = 0; b < 4; b++) expect_offer("stall");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(disp_valid == '0, "stall R3 R5 no room no offer", int'(disp_valid), 0);
        end
        retire(2);
        #1;
        check(disp_valid == '0, "stall R4 not yet offered", int'(disp_valid), 0);
        expect_offer("stall R5 resumed");
        check(last_wait == 1, "stall R4 offer two cycles after pulse", last_wait, 1);
        check(last_slot == 2, "stall R4 freed slot used", last_slot, 2);
        retire(0);
        expect_offer("stall R5 second");
        check(last_slot == 0, "stall R7 wraps to freed slot", last_slot, 0);
        retire_all("stall");
    endtask

    task automatic t_hold();
        logic [N-1:0] v0;
        disp_ready = '0;
        do_launch(2, 1, 1, 32, 1, 1);  // 32 threads, 1 warp
        expect_offer("hold");
        v0 = disp_valid;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(disp_valid == v0, "hold R10 valid held", int'(disp_valid), int'(v0));
            check(disp_block_id == 24'd0, "hold R10 id held", int'(disp_block_id), 0);
        end
        disp_ready = '1;
        @(negedge clk); #1;
        check(disp_valid == '0, "hold R10 closed after ready", int'(disp_valid), 0);
        expect_offer("hold next");
        retire_all("hold");
    endtask

    initial begin
        for (int s = 0; s < N; s++) begin
            m_free[s] = 24;
            m_blocks[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_reject();
        t_walk();
        t_stall();
        t_hold();
        summary();
        $finish;
    end

endmodule